// File: doc/BRIEF.md
# Sector Parity Code Generator for Page Streams

This block watches the data beats of one flash page as they stream past and builds a 24-bit Hamming-style parity code for every 512-byte sector of that page. A page holds one, two or four sectors, chosen by a small configuration field. Each beat carries one byte or one 32-bit word of four bytes. The beat flagged as last ends the page and closes whatever sector is open at that moment, even if that sector is only partly filled.

When a sector closes, its code is stored in one of four code registers. Each register carries a status byte whose bit 6 marks the code as valid. A status register reports busy while a page is in progress and for a fixed tail of cycles after the last beat. Software polls busy and then reads the codes through a small combinational read port. The codes can be written to the spare area on a program operation, or compared with stored codes on a read to locate a single flipped bit.

Top module: `page_ecc_gen`

## Requirements
- R1: For each sector, every data bit has a 12-bit address equal to its byte index within the sector times 8 plus its bit index. Code bit k (k = 0..11) is the XOR of all data bits whose address bit k is 1. Code bit 12+k is the XOR of all data bits whose address bit k is 0.
- R2: `page_cfg` selects the sectors per page: 1 gives one, 2 gives two, 3 gives four, and 0 acts like 1. Once the last configured sector has closed on its 512th byte, further beats are ignored until the last beat.
- R3: Reading `rd_addr` 0 to 3 returns the register of sector 0 to 3. The code sits in bits [23:0] and the status byte in bits [31:24]. The status byte is 8'h40 (bit 6 set) once the sector has closed in the current page. A sector that has not closed reads as all zero. Valid bits are never dropped during a page.
- R4: With `wide`=0, each beat supplies one byte from `data_in[7:0]` and the upper bits are ignored. With `wide`=1, each beat supplies four bytes, and the byte in `data_in[8k+7:8k]` has byte offset k within the beat. Word pages start on a 4-byte boundary.
- R5: The beat with `data_last` set closes the open sector. Its code is then computed over only the bytes received for that sector.
- R6: Reading `rd_addr` 4 returns busy in bit 6 and zero in all other bits. Busy rises after the first accepted beat of a page and stays high through the page. It then stays high for exactly BUSY_CYCLES clock cycles after the edge that takes the last beat, and then drops.
- R7: Beats offered during the busy tail after the last beat are ignored: they change no code, no valid bit and no busy state.
- R8: A new page starts with the first beat that arrives while not busy. At that edge, all four code registers and valid bits are cleared before that beat's bytes are accumulated.
- R9: Reading `rd_addr` 5 to 7 returns zero.
- R10: After reset, every register reads zero and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| page_cfg | input | 2 | Sectors per page selector |
| wide | input | 1 | 1: four bytes per beat, 0: one byte per beat |
| data_valid | input | 1 | A beat is present on data_in |
| data_last | input | 1 | Marks the final beat of the page |
| data_in | input | 32 | Beat data, lowest byte first |
| rd_addr | input | 3 | Register select for the read port |
| rd_data | output | 32 | Selected register value |

## Verification
On every cycle, the assertions check the following. Busy stays high for exactly the tail window after an accepted last beat and then drops. A page start leaves all valid bits clear. Valid bits never change during the tail and never fall during a page. Every code register's status byte is either zero or 8'h40. The parity values themselves, the sector-count selection, byte lane order, partial final sectors and the discarding of overflow beats can only be shown by the bench. The bench computes reference codes bit by bit over pseudo-random pages and compares every register with them.

// File: rtl/page_ecc_gen.sv
module page_ecc_gen #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  page_cfg,
  input  logic        wide,
  input  logic        data_valid,
  input  logic        data_last,
  input  logic [31:0] data_in,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic          active, full;
  logic [8:0]    bcnt;
  logic [1:0]    sec;
  logic [CW-1:0] post_cnt;
  logic [23:0]   acc;
  logic [23:0]   code_q [4];
  logic [3:0]    vld_q;

  logic tail, busy, beat, starting, take, close, sec_done;
  logic [1:0]  nsec_m1, sec_cur;
  logic [8:0]  b0;
  logic [9:0]  cnt_next;
  logic [23:0] nxt;
  logic [7:0]  lane_b;
  logic [8:0]  idx;
  logic        par;

  assign tail     = post_cnt != '0;
  assign busy     = active || tail;
  assign beat     = data_valid && !tail;
  assign starting = beat && !active;
  assign take     = beat && !(active && full);
  assign nsec_m1  = (page_cfg == 2'd3) ? 2'd3 : (page_cfg == 2'd2) ? 2'd1 : 2'd0;
  assign b0       = starting ? 9'd0 : bcnt;
  assign sec_cur  = starting ? 2'd0 : sec;
  assign cnt_next = {1'b0, b0} + (wide ? 10'd4 : 10'd1);
  assign sec_done = cnt_next[9];
  assign close    = take && (sec_done || data_last);

  always_comb begin
    nxt    = starting ? 24'd0 : acc;
    lane_b = '0;
    idx    = '0;
    par    = 1'b0;
    for (int l = 0; l < 4; l++) begin
      if (l == 0 || wide) begin
        lane_b = data_in[8*l +: 8];
        idx    = b0 + 9'(l);
        par    = ^lane_b;
        for (int i = 0; i < 8; i++)
          for (int k = 0; k < 3; k++)
            if (((i >> k) & 1) == 1) nxt[k] = nxt[k] ^ lane_b[i];
            else                     nxt[12+k] = nxt[12+k] ^ lane_b[i];
        for (int j = 0; j < 9; j++)
          if (idx[j]) nxt[3+j]  = nxt[3+j] ^ par;
          else        nxt[15+j] = nxt[15+j] ^ par;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      full     <= 1'b0;
      bcnt     <= '0;
      sec      <= '0;
      post_cnt <= '0;
      acc      <= '0;
      vld_q    <= '0;
      for (int s = 0; s < 4; s++) code_q[s] <= '0;
    end else begin
      if (starting) begin
        active <= 1'b1;
        full   <= 1'b0;
        vld_q  <= '0;
        for (int s = 0; s < 4; s++) code_q[s] <= '0;
      end
      if (take) begin
        if (close) begin
          code_q[sec_cur] <= nxt;
          vld_q[sec_cur]  <= 1'b1;
          acc             <= '0;
          bcnt            <= '0;
          if (sec_cur == nsec_m1) begin
            if (!data_last) full <= 1'b1;
            sec <= sec_cur;
          end else begin
            sec <= sec_cur + 2'd1;
          end
        end else begin
          acc  <= nxt;
          bcnt <= cnt_next[8:0];
          sec  <= sec_cur;
        end
      end
      if (beat && data_last) begin
        active   <= 1'b0;
        full     <= 1'b0;
        post_cnt <= CW'(BUSY_CYCLES);
      end else if (tail) begin
        post_cnt <= post_cnt - 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0, 3'd1, 3'd2, 3'd3:
        rd_data = {1'b0, vld_q[rd_addr[1:0]], 6'b0, code_q[rd_addr[1:0]]};
      3'd4:    rd_data = {25'b0, busy, 6'b0};
      default: rd_data = 32'd0;
    endcase
  end
endmodule

// File: rtl/page_ecc_gen_chk.sv
module page_ecc_gen_chk #(
  parameter int BUSY_CYCLES = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        data_valid,
  input logic        data_last,
  input logic        busy,
  input logic        tail,
  input logic        active,
  input logic [3:0]  vld_q,
  input logic [2:0]  rd_addr,
  input logic [31:0] rd_data
);
  localparam int SW = $clog2(BUSY_CYCLES + 2) + 1;
  logic [SW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (data_valid && data_last && !tail) since <= SW'(1);
    else if (since != '0 && since <= SW'(BUSY_CYCLES)) since <= since + 1'b1;
    else since <= '0;
  end

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (since != '0 && since <= SW'(BUSY_CYCLES)) |-> busy); // R6
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (since == SW'(BUSY_CYCLES + 1)) |-> !busy); // R6
  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !busy && !data_last) |=> (vld_q == 4'd0)); // R8
  AST_TAIL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    tail |=> $stable(vld_q)); // R7
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> ((vld_q & $past(vld_q)) == $past(vld_q))); // R3

  always_comb begin
    if (rst_n && rd_addr < 3'd4)
      AST_STATUS_FMT: assert (rd_data[31:24] == 8'h00 || rd_data[31:24] == 8'h40); // R3
  end
endmodule

bind page_ecc_gen page_ecc_gen_chk #(.BUSY_CYCLES(BUSY_CYCLES)) i_page_ecc_gen_chk (
  .clk(clk), .rst_n(rst_n), .data_valid(data_valid), .data_last(data_last),
  .busy(busy), .tail(tail), .active(active), .vld_q(vld_q),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_page_ecc_gen.sv
module test_page_ecc_gen;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 4;
  localparam int NVEC = 9;
  // cfg, wide, bytes in page, seed, offer beats during tail
  localparam int VEC [NVEC][5] = '{
    '{1, 0,  512, 11, 0},
    '{2, 0, 1024, 22, 1},
    '{3, 1, 2048, 33, 0},
    '{3, 0, 2048, 44, 1},
    '{2, 1,  700, 55, 0},
    '{1, 1, 1024, 66, 0},
    '{0, 0,  512, 77, 1},
    '{3, 1, 1300, 88, 0},
    '{1, 0,  100, 99, 0}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] page_cfg = 0;
  logic wide = 0, data_valid = 0, data_last = 0;
  logic [31:0] data_in = 0;
  logic [2:0] rd_addr = 0;
  logic [31:0] rd_data;
  logic [7:0] mem [2048];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_ecc_gen #(.BUSY_CYCLES(BUSY)) i_page_ecc_gen (
    .clk(clk), .rst_n(rst_n), .page_cfg(page_cfg), .wide(wide),
    .data_valid(data_valid), .data_last(data_last), .data_in(data_in),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_code(int base, int len);
    logic [11:0] odd = 0, even = 0;
    for (int a = 0; a < len*8; a++) begin
      logic d = mem[base + (a >> 3)][a & 7];
      for (int k = 0; k < 12; k++)
        if (((a >> k) & 1) == 1) odd[k] = odd[k] ^ d;
        else                     even[k] = even[k] ^ d;
    end
    return {even, odd};
  endfunction

  task automatic fill(int seed);
    logic [31:0] x = 32'(seed) * 32'h9E3779B1 + 32'd1;
    for (int i = 0; i < 2048; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      mem[i] = x[7:0];
    end
  endtask

  task automatic read_reg(int a, output logic [31:0] v);
    rd_addr = 3'(a);
    #1;
    v = rd_data;
  endtask

  task automatic run_page(int cfg, int w, int nb, int junk);
    int beats = (w != 0) ? nb / 4 : nb;
    int nsec = (cfg == 3) ? 4 : (cfg == 2) ? 2 : 1;
    logic [31:0] v, e;
    page_cfg = 2'(cfg);
    wide = (w != 0);
    rd_addr = 3'd4;
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      if (b == 1) chk("R6 busy during page", rd_data, 32'h40);
      data_valid = 1;
      data_last = (b == beats - 1);
      if (w != 0) data_in = {mem[4*b+3], mem[4*b+2], mem[4*b+1], mem[4*b]};
      else        data_in = {24'hA5C3E1, mem[b]};
    end
    for (int n = 1; n <= BUSY + 1; n++) begin
      @(negedge clk);
      if (junk != 0 && n <= 2) begin
        data_valid = 1; data_last = 1; data_in = 32'hFFFF_FFFF;
      end else begin
        data_valid = 0; data_last = 0;
      end
      chk(n <= BUSY ? "R6 busy tail" : "R6 busy dropped", rd_data, n <= BUSY ? 32'h40 : 32'h0);
    end
    for (int s = 0; s < 4; s++) begin
      int st = s * 512;
      if (s < nsec && st < nb) e = {8'h40, ref_code(st, (nb - st) < 512 ? (nb - st) : 512)};
      else e = 32'h0;
      read_reg(s, v);
      if (junk != 0) chk("R7 code after tail beats", v, e);
      else if (nb % 512 != 0 && s < nsec && st < nb && nb - st < 512) chk("R5 partial sector code", v, e);
      else if (s >= nsec || st >= nb) chk("R2 unused sector", v, e);
      else if (w != 0) chk("R4 word lane code", v, e);
      else chk("R1 sector code", v, e);
    end
    read_reg(4, v);
    chk("R7 idle after tail", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R6 watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      read_reg(a, v);
      chk("R10 reset value", v, 32'h0);
    end

    for (int i = 0; i < NVEC; i++) begin
      fill(VEC[i][3]);
      run_page(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][4]);
    end

    read_reg(5, v); chk("R9 unmapped 5", v, 32'h0);
    read_reg(7, v); chk("R9 unmapped 7", v, 32'h0);

    fill(123);
    page_cfg = 2'd1; wide = 0;
    @(negedge clk);
    data_valid = 1; data_last = 0; data_in = {24'h0, mem[0]};
    @(negedge clk);
    data_valid = 0;
    for (int s = 0; s < 4; s++) begin
      read_reg(s, v);
      chk("R8 cleared at page start", v, 32'h0);
    end
    read_reg(4, v);
    chk("R6 busy after first beat", v, 32'h40);
    @(negedge clk);
    data_valid = 1; data_last = 1; data_in = {24'h0, mem[1]};
    @(negedge clk);
    data_valid = 0; data_last = 0;
    repeat (BUSY + 1) @(negedge clk);
    read_reg(0, v);
    chk("R5 two-byte sector", v, {8'h40, ref_code(0, 2)});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule